// File: doc/BRIEF.md
# Symmetric Seven-Segment Vector Sequencer

This block plays one modulation period of a hybrid two/three-level three-phase bridge. A controller sends it three switching vectors and three dwell counts: one redundant small vector, given in its upper (P-type) form, two large vectors, and the tick counts each should be applied for. Over a fixed period of `PERIOD_TICKS` clock ticks it emits the per-phase P/O/N state of the active vector. The seven segments mirror about the centre: small form, large A, large B, the other small form, large B, large A, and the first small form again. A select bit chooses whether the upper or the lower small form sits on the two outer segments. The other form goes in the centre.

The small vector's dwell is split into a quarter on each outer segment and the remainder in the centre. Each large vector's dwell is split into a lower half on the first pass and the remainder on the mirrored pass. Segments of zero length never appear on the outputs. A new parameter set can be loaded at any tick. It waits in a shadow register and replaces the working set only at the next period boundary, so a period is never built from two parameter sets. The default period is 2000 ticks, which is a 6 kHz period from a 12 MHz tick clock. Vector and dwell computation, and gate decoding, happen elsewhere.

Top module: `svm_seq7`

## Requirements
- R1: While reset is held and in the first cycle after it is released, all three phase outputs read O, `seg_idx` reads 6 and `period_start` is high.
- R2: `period_start` is high for exactly one cycle in every `PERIOD_TICKS` cycles, and that cycle is the first tick of a period.
- R3: With small dwell ta and large dwells tb and tc, the segment lengths in order are floor(ta/4), floor(tb/2), floor(tc/2), ta-2*floor(ta/4), tc-floor(tc/2), tb-floor(tb/2) and floor(ta/4).
- R4: The segments play in the order outer small, large A, large B, centre small, large B, large A, outer small, and `seg_idx` reports them as 0 to 6.
- R5: Phase codes are N=0, O=1 and P=2. A vector code holds phase A in bits [5:4], phase B in bits [3:2] and phase C in bits [1:0]. The lower small form lowers each phase of `small_p` by one level, with N staying N. When `outer_p` is 1 the outer segments carry `small_p` and the centre carries the lower form. When `outer_p` is 0 the two are swapped.
- R6: A segment of zero length never appears on `seg_idx` or on the phase outputs.
- R7: If the seven lengths sum to less than the period, segment 6 lasts to the end of the period. If they sum to more, the period ends on schedule and the remaining segments are cut off.
- R8: A parameter set loaded during a period has no effect on the outputs until the next period start, and it is used from that tick on.
- R9: If several loads fall within one period, only the last of them is used.
- R10: A load on the last tick of a period is used from the very next period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Capture the parameter inputs on this tick |
| small_p | input | 6 | Small vector, upper form |
| large_a | input | 6 | Large vector on segments 1 and 5 |
| large_b | input | 6 | Large vector on segments 2 and 4 |
| outer_p | input | 1 | 1: upper small form on the outer segments |
| dwell_s | input | DWELL_W | Small vector dwell in ticks |
| dwell_a | input | DWELL_W | Large vector A dwell in ticks |
| dwell_b | input | DWELL_W | Large vector B dwell in ticks |
| phase_a | output | 2 | Phase A state |
| phase_b | output | 2 | Phase B state |
| phase_c | output | 2 | Phase C state |
| seg_idx | output | 3 | Current segment, 0 to 6 |
| period_start | output | 1 | High on the first tick of each period |

## Verification
The bench uses a short period and sweeps small dwells from zero to nearly a whole period against several large-dwell pairs. It compares each tick with an arithmetic model, so odd dwells expose rounding errors in the quarter and half splits. Zero dwells expose segments that are shown when they should be skipped. Sums that fall short of the period and sums that exceed it separate the stretching of segment 6 from truncation at the period end. The configurations alternate between the two small-form placements, which shows whether the outer and centre forms are swapped. Loads are placed at a different tick in each period, sometimes twice and sometimes on the last tick, so that early application, a stale shadow and a lost boundary load each produce a mismatch.

// File: rtl/svm_seq7_pkg.sv
package svm_seq7_pkg;

  localparam logic [1:0] LVL_N = 2'd0;
  localparam logic [1:0] LVL_O = 2'd1;
  localparam logic [1:0] LVL_P = 2'd2;

  localparam logic [5:0] VEC_ZERO_O = {LVL_O, LVL_O, LVL_O};

  // one level lower, saturating at N
  function automatic logic [1:0] lvl_down(input logic [1:0] lv);
    return (lv == LVL_P) ? LVL_O : LVL_N;
  endfunction

  function automatic logic [5:0] vec_down(input logic [5:0] v);
    return {lvl_down(v[5:4]), lvl_down(v[3:2]), lvl_down(v[1:0])};
  endfunction

  // length of segment k given the three dwell counts
  function automatic int unsigned seg_ticks(input int unsigned k,
                                            input int unsigned ts,
                                            input int unsigned ta,
                                            input int unsigned tb);
    int unsigned q;
    q = ts >> 2;
    case (k)
      0, 6:    return q;
      1:       return ta >> 1;
      2:       return tb >> 1;
      3:       return ts - (q << 1);
      4:       return tb - (tb >> 1);
      default: return ta - (ta >> 1);
    endcase
  endfunction

  // vector applied during segment seg
  function automatic logic [5:0] pick_vec(input logic [2:0] seg,
                                          input logic [5:0] sp,
                                          input logic [5:0] la,
                                          input logic [5:0] lb,
                                          input logic       op);
    logic [5:0] sn;
    sn = vec_down(sp);
    case (seg)
      3'd0, 3'd6: return op ? sp : sn;
      3'd1, 3'd5: return la;
      3'd2, 3'd4: return lb;
      default:    return op ? sn : sp;
    endcase
  endfunction

endpackage

// File: rtl/svm_seq7_tick_ctr.sv
module svm_seq7_tick_ctr #(
  parameter int PERIOD_TICKS = 2000,
  localparam int CNT_W = $clog2(PERIOD_TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] tick,
  output logic             first_tick,
  output logic             last_tick
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);

  logic [CNT_W-1:0] tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tick_q <= '0;
    else if (tick_q == LAST)
      tick_q <= '0;
    else
      tick_q <= tick_q + 1'b1;
  end

  assign tick       = tick_q;
  assign first_tick = (tick_q == '0);
  assign last_tick  = (tick_q == LAST);

endmodule

// File: rtl/svm_seq7_param_buf.sv
module svm_seq7_param_buf #(
  parameter int             W       = 8,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         swap,
  output logic [W-1:0] active
);

  logic [W-1:0] shadow_q;
  logic [W-1:0] active_q;
  logic [W-1:0] next_set;

  // a load on the swap tick goes straight through
  assign next_set = load ? din : shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= RST_VAL;
      active_q <= RST_VAL;
    end else begin
      shadow_q <= next_set;
      if (swap)
        active_q <= next_set;
    end
  end

  assign active = active_q;

endmodule

// File: rtl/svm_seq7_seg_decode.sv
module svm_seq7_seg_decode
  import svm_seq7_pkg::*;
#(
  parameter int DWELL_W = 12,
  parameter int CNT_W   = 11,
  localparam int SUM_W  = DWELL_W + 3,
  localparam int CMP_W  = (SUM_W > CNT_W) ? SUM_W : CNT_W
) (
  input  logic [CNT_W-1:0]   tick,
  input  logic [5:0]         sp,
  input  logic [5:0]         la,
  input  logic [5:0]         lb,
  input  logic               op,
  input  logic [DWELL_W-1:0] ts,
  input  logic [DWELL_W-1:0] ta,
  input  logic [DWELL_W-1:0] tb,
  output logic [2:0]         seg,
  output logic [5:0]         vec
);

  logic [SUM_W-1:0] len [7];
  logic [SUM_W-1:0] edge_end [7];
  logic [6:0]       hit;

  for (genvar k = 0; k < 7; k++) begin : g_seg
    assign len[k] = SUM_W'(seg_ticks(k, 32'(ts), 32'(ta), 32'(tb)));
    if (k == 0) begin : g_first
      assign edge_end[k] = len[k];
    end else begin : g_next
      assign edge_end[k] = edge_end[k-1] + len[k];
    end
    assign hit[k] = CMP_W'(tick) < CMP_W'(edge_end[k]);
  end

  // earliest segment whose end lies beyond the tick; 6 when none
  always_comb begin
    seg = 3'd6;
    for (int k = 6; k >= 0; k--)
      if (hit[k]) seg = 3'(k);
  end

  assign vec = pick_vec(seg, sp, la, lb, op);

endmodule

// File: rtl/svm_seq7.sv
module svm_seq7
  import svm_seq7_pkg::*;
#(
  parameter int PERIOD_TICKS = 2000,
  parameter int DWELL_W      = 12,
  localparam int CNT_W       = $clog2(PERIOD_TICKS),
  localparam int CFG_W       = 19 + 3 * DWELL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [5:0]         small_p,
  input  logic [5:0]         large_a,
  input  logic [5:0]         large_b,
  input  logic               outer_p,
  input  logic [DWELL_W-1:0] dwell_s,
  input  logic [DWELL_W-1:0] dwell_a,
  input  logic [DWELL_W-1:0] dwell_b,
  output logic [1:0]         phase_a,
  output logic [1:0]         phase_b,
  output logic [1:0]         phase_c,
  output logic [2:0]         seg_idx,
  output logic               period_start
);

  localparam logic [CFG_W-1:0] CFG_RST =
    {VEC_ZERO_O, VEC_ZERO_O, VEC_ZERO_O, 1'b1, {(3 * DWELL_W){1'b0}}};

  logic [CNT_W-1:0]   tick;
  logic               first_tick;
  logic               last_tick;
  logic [CFG_W-1:0]   cfg_in;
  logic [CFG_W-1:0]   act_cfg;
  logic [5:0]         a_sp, a_la, a_lb;
  logic               a_op;
  logic [DWELL_W-1:0] a_ts, a_ta, a_tb;
  logic [5:0]         cur_vec;

  svm_seq7_tick_ctr #(.PERIOD_TICKS(PERIOD_TICKS)) tick_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .first_tick (first_tick),
    .last_tick  (last_tick)
  );

  assign cfg_in = {small_p, large_a, large_b, outer_p, dwell_s, dwell_a, dwell_b};

  svm_seq7_param_buf #(.W(CFG_W), .RST_VAL(CFG_RST)) buf_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .din    (cfg_in),
    .swap   (last_tick),
    .active (act_cfg)
  );

  assign {a_sp, a_la, a_lb, a_op, a_ts, a_ta, a_tb} = act_cfg;

  svm_seq7_seg_decode #(.DWELL_W(DWELL_W), .CNT_W(CNT_W)) dec_i (
    .tick (tick),
    .sp   (a_sp),
    .la   (a_la),
    .lb   (a_lb),
    .op   (a_op),
    .ts   (a_ts),
    .ta   (a_ta),
    .tb   (a_tb),
    .seg  (seg_idx),
    .vec  (cur_vec)
  );

  assign phase_a      = cur_vec[5:4];
  assign phase_b      = cur_vec[3:2];
  assign phase_c      = cur_vec[1:0];
  assign period_start = first_tick;

endmodule

// File: rtl/svm_seq7_chk.sv
module svm_seq7_chk #(
  parameter int PERIOD_TICKS = 2000,
  parameter int CFG_W        = 55
) (
  input logic             clk,
  input logic             rst_n,
  input logic             period_start,
  input logic [2:0]       seg_idx,
  input logic [1:0]       phase_a,
  input logic [1:0]       phase_b,
  input logic [1:0]       phase_c,
  input logic [CFG_W-1:0] act_cfg
);

  int unsigned since_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      since_start <= 0;
    else if (since_start == PERIOD_TICKS - 1)
      since_start <= 0;
    else
      since_start <= since_start + 1;
  end

  AST_PERIOD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    period_start == (since_start == 0)); // R2

  AST_SEG_NO_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |-> (seg_idx >= $past(seg_idx))); // R4

  AST_SEG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_idx <= 3'd6); // R4

  AST_LEGAL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_a != 2'd3) && (phase_b != 2'd3) && (phase_c != 2'd3)); // R5

  AST_HOLD_IN_SEG: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_start && seg_idx == $past(seg_idx)) |->
      $stable({phase_a, phase_b, phase_c})); // R3

  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |-> $stable(act_cfg)); // R8

endmodule

bind svm_seq7 svm_seq7_chk #(.PERIOD_TICKS(PERIOD_TICKS), .CFG_W(CFG_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .period_start (period_start),
  .seg_idx      (seg_idx),
  .phase_a      (phase_a),
  .phase_b      (phase_b),
  .phase_c      (phase_c),
  .act_cfg      (act_cfg)
);

// File: tb/svm_seq7_tb_top.sv
module svm_seq7_tb_top;

  localparam int P  = 32;
  localparam int DW = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, load, outer_p;
  logic [5:0]    small_p, large_a, large_b;
  logic [DW-1:0] dwell_s, dwell_a, dwell_b;
  logic [1:0]    phase_a, phase_b, phase_c;
  logic [2:0]    seg_idx;
  logic          period_start;

  int n_chk  = 0;
  int n_fail = 0;

  // expected (currently active) configuration
  logic [5:0] c_sp, c_la, c_lb;
  logic       c_op;
  int         c_ts, c_ta, c_tb;
  string      c_tag;

  svm_seq7 #(.PERIOD_TICKS(P), .DWELL_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .load(load),
    .small_p(small_p), .large_a(large_a), .large_b(large_b), .outer_p(outer_p),
    .dwell_s(dwell_s), .dwell_a(dwell_a), .dwell_b(dwell_b),
    .phase_a(phase_a), .phase_b(phase_b), .phase_c(phase_c),
    .seg_idx(seg_idx), .period_start(period_start)
  );

  function automatic logic [1:0] one_down(input logic [1:0] x);
    return (x == 2'd0) ? 2'd0 : x - 2'd1;
  endfunction

  // model: which segment tick t falls in, and the vector shown there
  task automatic model(input int t, output int seg, output logic [5:0] v);
    int len[7];
    int acc;
    logic [5:0] lo;
    len[0] = c_ts / 4;  len[6] = c_ts / 4;
    len[3] = c_ts - 2 * (c_ts / 4);
    len[1] = c_ta / 2;  len[5] = c_ta - c_ta / 2;
    len[2] = c_tb / 2;  len[4] = c_tb - c_tb / 2;
    seg = 6;
    acc = 0;
    for (int k = 0; k < 7; k++) begin
      acc += len[k];
      if (t < acc) begin
        seg = k;
        break;
      end
    end
    lo = {one_down(c_sp[5:4]), one_down(c_sp[3:2]), one_down(c_sp[1:0])};
    case (seg)
      0, 6: v = c_op ? c_sp : lo;
      3:    v = c_op ? lo : c_sp;
      1, 5: v = c_la;
      default: v = c_lb;
    endcase
  endtask

  task automatic check_cycle(input int t);
    int exp_seg;
    logic [5:0] exp_v;
    model(t, exp_seg, exp_v);
    n_chk++;  // R2
    if (period_start !== (t == 0)) begin
      n_fail++;
      $display("FAIL R2 tick %0d period_start: actual=%0b expected=%0b", t, period_start, (t == 0));
    end
    n_chk++;  // R3 R4 R6 R7
    if (seg_idx !== 3'(exp_seg)) begin
      n_fail++;
      $display("FAIL R3 R4 R6 R7 tick %0d seg_idx: actual=%0d expected=%0d", t, seg_idx, exp_seg);
    end
    n_chk++;  // R5 R8 plus R9 or R10 when tagged
    if ({phase_a, phase_b, phase_c} !== exp_v) begin
      n_fail++;
      $display("FAIL %s tick %0d phases: actual=%h expected=%h", c_tag, t,
               {phase_a, phase_b, phase_c}, exp_v);
    end
  endtask

  task automatic drive(input logic [5:0] sp, la, lb, input logic op, input int ts, ta, tb);
    load = 1'b1;
    small_p = sp; large_a = la; large_b = lb; outer_p = op;
    dwell_s = DW'(ts); dwell_a = DW'(ta); dwell_b = DW'(tb);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int ts_set[9] = '{0, 1, 2, 3, 4, 5, 7, 12, 30};
    int ta_set[4] = '{0, 1, 3, 6};
    int tb_set[3] = '{0, 2, 5};
    int n;
    logic [5:0] n_sp, n_la, n_lb;
    logic n_op;
    int n_ts, n_ta, n_tb, ldpos;
    bit twice;
    string n_tag;

    rst_n = 1'b0; load = 1'b0;
    small_p = '0; large_a = '0; large_b = '0; outer_p = 1'b0;
    dwell_s = '0; dwell_a = '0; dwell_b = '0;
    repeat (3) @(negedge clk);
    // R1: values under reset
    n_chk++;
    if ({phase_a, phase_b, phase_c} !== 6'h15 || seg_idx !== 3'd6 || period_start !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 in reset: actual=%h/%0d/%0b expected=15/6/1",
               {phase_a, phase_b, phase_c}, seg_idx, period_start);
    end
    rst_n = 1'b1;

    // R1: reset set is OOO with zero dwells, so segment 6 for the whole period
    c_sp = 6'h15; c_la = 6'h15; c_lb = 6'h15; c_op = 1'b1;
    c_ts = 0; c_ta = 0; c_tb = 0; c_tag = "R1";

    n = 0;
    foreach (ts_set[i]) foreach (ta_set[j]) foreach (tb_set[k]) begin
      // region-2 style (lower small outer) and region-3 style (upper small outer)
      if (n % 2 == 0) begin
        n_sp = 6'b10_01_01; n_la = 6'b10_00_00; n_lb = 6'b10_10_00; n_op = 1'b0;
      end else begin
        n_sp = 6'b10_10_01; n_la = 6'b10_10_00; n_lb = 6'b10_00_00; n_op = 1'b1;
      end
      n_ts = ts_set[i]; n_ta = ta_set[j]; n_tb = tb_set[k];
      ldpos = (n * 7) % P;
      if (n % 11 == 3) ldpos = P - 1;
      twice = (n % 5 == 0) && (ldpos > 0);
      n_tag = twice ? "R9" : (ldpos == P - 1) ? "R10" : "R5 R8";
      for (int t = 0; t < P; t++) begin
        load = 1'b0;
        if (twice && t == 0)
          drive(6'b01_01_01, 6'b00_00_00, 6'b10_10_10, ~n_op, 9, 9, 9);
        if (t == ldpos)
          drive(n_sp, n_la, n_lb, n_op, n_ts, n_ta, n_tb);
        #1;
        check_cycle(t);  // old set still shown: R8
        @(negedge clk);
      end
      load = 1'b0;
      c_sp = n_sp; c_la = n_la; c_lb = n_lb; c_op = n_op;
      c_ts = n_ts; c_ta = n_ta; c_tb = n_tb; c_tag = n_tag;
      n++;
    end
    // final period with the last set
    for (int t = 0; t < P; t++) begin
      #1;
      check_cycle(t);
      @(negedge clk);
    end
    summary();
    $finish;
  end

endmodule